// File: doc/BRIEF.md
# Temperature Sensor Configuration Register with Lock Protection

This block holds the configuration word of a temperature-monitoring device. It sits behind a simple register port: an address, write data, a write enable and combinational read data, with an active-low power-on reset. The word carries a shutdown control, two lock bits that protect the alarm threshold registers, a write-only strobe that clears a pending event, and a read-only copy of the event output.

The lock bits can only be set. Once a lock is written to 1 it holds until the next power-on reset. A set lock stops writes to the threshold registers it guards, and also stops the sensor from being put into shutdown. Taking the sensor out of shutdown is always allowed. The block drives qualified write enables for the critical threshold register and for the upper and lower window registers. It also drives a shutdown level and a one-cycle clear-event pulse for the event logic that lives outside it.

Top module: `tsen_cfg_reg`

## Requirements
- R1: After reset, shutdown_o is 0, both locks are 0, clr_event_o is 0, and a read of the configuration address (01h) returns 0 while event_active_i is 0.
- R2: Writing 1 to bit 7 (critical lock) or bit 6 (window lock) at address 01h sets that lock with a single write, and it reads back 1. A later write of 0 leaves it set until reset.
- R3: While either lock is set, a write of 1 to bit 8 (shutdown) is ignored and shutdown_o stays 0.
- R4: A write of 0 to bit 8 always clears shutdown_o, whether or not a lock is set. A write of 1 with no lock set drives shutdown_o to 1 from the next cycle, and bit 8 reads it back.
- R5: When one write sets a lock and bit 8 together, shutdown is accepted only if neither lock was set before that write. The lock is set in either case.
- R6: crit_we_o is high in the same cycle that we_i is high with addr_i equal to 04h, unless the critical lock is set, in which case it stays low.
- R7: win_we_o is high in the same cycle that we_i is high with addr_i equal to 02h or 03h, unless the window lock is set, in which case it stays low.
- R8: Bit 5 (clear event) always reads 0. A write of 1 to it gives a clr_event_o pulse one cycle long in the cycle after the write, but only when intr_mode_i is 1. With intr_mode_i at 0 there is no pulse.
- R9: Bit 4 reads the current value of event_active_i. Writes to bit 4 have no effect.
- R10: Bits 15..9 and 3..0 read 0 and ignore writes. Reads of any other address return 0, and writes to any other address leave the configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| addr_i | input | 8 | Register address |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | Write enable |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| event_active_i | input | 1 | Event output is currently asserted by an alarm |
| intr_mode_i | input | 1 | 1 = interrupt mode, 0 = comparator mode |
| shutdown_o | output | 1 | Sensor shutdown level |
| crit_we_o | output | 1 | Qualified write enable for the critical threshold register |
| win_we_o | output | 1 | Qualified write enable for the upper and lower threshold registers |
| clr_event_o | output | 1 | One-cycle clear-event pulse |

## Verification
The hardest case is a single write that sets a lock and requests shutdown in the same cycle. The result depends on whether a lock was already set before that write, and locks cannot be cleared except by reset. The bench therefore resets the block before each ordering. It first writes lock and shutdown together from a fresh reset, and expects shutdown to be taken. It then sets the window lock first and repeats the combined write, and expects shutdown to be refused. It also leaves shutdown after a lock has been set, to show that the lock blocks only the entry into shutdown.

// File: rtl/tsen_cfg_pkg.sv
package tsen_cfg_pkg;
  // bit positions inside the configuration word
  localparam int unsigned SD_BIT    = 8;
  localparam int unsigned CLOCK_BIT = 7;
  localparam int unsigned WLOCK_BIT = 6;
  localparam int unsigned CLR_BIT   = 5;
  localparam int unsigned EVT_BIT   = 4;
  localparam int unsigned NUM_LOCKS = 2;
  localparam int unsigned LK_CRIT   = 0;
  localparam int unsigned LK_WIN    = 1;

  typedef struct packed {
    logic cfg;
    logic crit;
    logic win;
  } hit_t;
endpackage

// File: rtl/tsen_cfg_decode.sv
module tsen_cfg_decode
  import tsen_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NUM_WIN = 2,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h01,
  parameter logic [ADDR_W-1:0] CRIT_ADDR = 8'h04,
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_ADDRS = {8'h03, 8'h02}
) (
  input  logic [ADDR_W-1:0] addr_i,
  output hit_t              hit_o
);
  logic [NUM_WIN-1:0] win_match;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    assign win_match[g] = (addr_i == WIN_ADDRS[g*ADDR_W +: ADDR_W]);
  end

  assign hit_o.cfg  = (addr_i == CFG_ADDR);
  assign hit_o.crit = (addr_i == CRIT_ADDR);
  assign hit_o.win  = |win_match;
endmodule

// File: rtl/tsen_lock_bits.sv
module tsen_lock_bits #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] lock_o
);
  // set-only, cleared by power-on reset alone
  for (genvar g = 0; g < N; g++) begin : g_lock
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      lock_o[g] <= 1'b0;
      else if (set_i[g]) lock_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/tsen_sd_ctrl.sv
module tsen_sd_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic sd_wdata_i,
  input  logic any_lock_i,  // lock state before this write
  output logic sd_o
);
  logic sd_d;

  always_comb begin
    sd_d = sd_o;
    if (wr_i) begin
      if (!sd_wdata_i)      sd_d = 1'b0;
      else if (!any_lock_i) sd_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sd_o <= 1'b0;
    else         sd_o <= sd_d;
  end
endmodule

// File: rtl/tsen_clr_pulse.sv
module tsen_clr_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic intr_mode_i,
  output logic pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= req_i & intr_mode_i;
  end
endmodule

// File: rtl/tsen_cfg_reg.sv
module tsen_cfg_reg
  import tsen_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h01,
  parameter logic [ADDR_W-1:0] CRIT_ADDR = 8'h04,
  parameter logic [2*ADDR_W-1:0] WIN_ADDRS = {8'h03, 8'h02}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              event_active_i,
  input  logic              intr_mode_i,
  output logic              shutdown_o,
  output logic              crit_we_o,
  output logic              win_we_o,
  output logic              clr_event_o
);
  hit_t                 hit;
  logic                 cfg_wr;
  logic [NUM_LOCKS-1:0] lock_set, lock_q;
  logic                 crit_lock, win_lock;
  logic                 unused_wdata;

  tsen_cfg_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_WIN  (2),
    .CFG_ADDR (CFG_ADDR),
    .CRIT_ADDR(CRIT_ADDR),
    .WIN_ADDRS(WIN_ADDRS)
  ) u_dec (
    .addr_i(addr_i),
    .hit_o (hit)
  );

  assign cfg_wr = we_i & hit.cfg;

  assign lock_set[LK_CRIT] = cfg_wr & wdata_i[CLOCK_BIT];
  assign lock_set[LK_WIN]  = cfg_wr & wdata_i[WLOCK_BIT];

  tsen_lock_bits #(.N(NUM_LOCKS)) u_lock (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (lock_set),
    .lock_o(lock_q)
  );

  assign crit_lock = lock_q[LK_CRIT];
  assign win_lock  = lock_q[LK_WIN];

  tsen_sd_ctrl u_sd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cfg_wr),
    .sd_wdata_i(wdata_i[SD_BIT]),
    .any_lock_i(|lock_q),
    .sd_o      (shutdown_o)
  );

  tsen_clr_pulse u_clr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (cfg_wr & wdata_i[CLR_BIT]),
    .intr_mode_i(intr_mode_i),
    .pulse_o    (clr_event_o)
  );

  assign crit_we_o = we_i & hit.crit & ~crit_lock;
  assign win_we_o  = we_i & hit.win  & ~win_lock;

  always_comb begin
    rdata_o = '0;
    if (hit.cfg) begin
      rdata_o[SD_BIT]    = shutdown_o;
      rdata_o[CLOCK_BIT] = crit_lock;
      rdata_o[WLOCK_BIT] = win_lock;
      rdata_o[EVT_BIT]   = event_active_i;
    end
  end

  assign unused_wdata = ^{wdata_i[DATA_W-1:SD_BIT+1], wdata_i[EVT_BIT:0]};
endmodule

// File: rtl/tsen_cfg_reg_chk.sv
module tsen_cfg_reg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_wr_i,
  input logic [15:0] wdata_i,
  input logic        crit_lock_i,
  input logic        win_lock_i,
  input logic        shutdown_o,
  input logic        crit_we_o,
  input logic        win_we_o,
  input logic        clr_event_o,
  input logic        intr_mode_i,
  input logic [15:0] rdata_o
);
  AST_CRIT_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_lock_i |=> crit_lock_i); // R2
  AST_WIN_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_lock_i |=> win_lock_i); // R2
  AST_SD_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && wdata_i[8] && (crit_lock_i || win_lock_i) && !shutdown_o) |=> !shutdown_o); // R3
  AST_SD_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && !wdata_i[8]) |=> !shutdown_o); // R4
  AST_CRIT_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_lock_i |-> !crit_we_o); // R6
  AST_WIN_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_lock_i |-> !win_we_o); // R7
  AST_CLR_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_event_o |-> $past(intr_mode_i) && $past(cfg_wr_i)); // R8
  AST_RD_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[15:9] == '0) && (rdata_o[5] == 1'b0) && (rdata_o[3:0] == '0)); // R10
endmodule

bind tsen_cfg_reg tsen_cfg_reg_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_wr_i   (cfg_wr),
  .wdata_i    (wdata_i),
  .crit_lock_i(crit_lock),
  .win_lock_i (win_lock),
  .shutdown_o (shutdown_o),
  .crit_we_o  (crit_we_o),
  .win_we_o   (win_we_o),
  .clr_event_o(clr_event_o),
  .intr_mode_i(intr_mode_i),
  .rdata_o    (rdata_o)
);

// File: tb/tsen_cfg_reg_tb.sv
module tsen_cfg_reg_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic [15:0] rdata_o;
  logic        event_active_i = 1'b0;
  logic        intr_mode_i = 1'b0;
  logic        shutdown_o, crit_we_o, win_we_o, clr_event_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  tsen_cfg_reg u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .rdata_o(rdata_o), .event_active_i(event_active_i),
    .intr_mode_i(intr_mode_i), .shutdown_o(shutdown_o), .crit_we_o(crit_we_o),
    .win_we_o(win_we_o), .clr_event_o(clr_event_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; we_i = 1'b0; addr_i = '0; wdata_i = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    rd(8'h01, v);
    chk("R1 cfg read", v, 16'h0000);
    chk("R1 shutdown", {15'd0, shutdown_o}, 16'd0);
    chk("R1 clr", {15'd0, clr_event_o}, 16'd0);
  endtask

  task automatic t_shutdown();
    logic [15:0] v;
    do_reset();
    wr(8'h01, 16'h0100);
    chk("R4 sd enter", {15'd0, shutdown_o}, 16'd1);
    rd(8'h01, v);
    chk("R4 sd readback", v, 16'h0100);
    wr(8'h01, 16'h0000);
    chk("R4 sd exit", {15'd0, shutdown_o}, 16'd0);
  endtask

  task automatic t_status_rsvd();
    logic [15:0] v;
    do_reset();
    intr_mode_i = 1'b0;
    event_active_i = 1'b1;
    rd(8'h01, v);
    chk("R9 evt high", v, 16'h0010);
    wr(8'h01, 16'hFE3F);
    chk("R8 no pulse comparator mode", {15'd0, clr_event_o}, 16'd0);
    event_active_i = 1'b0;
    rd(8'h01, v);
    chk("R10 rsvd ignored, R9 evt low", v, 16'h0000);
    rd(8'h05, v);
    chk("R10 other addr reads 0", v, 16'h0000);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    do_reset();
    intr_mode_i = 1'b1;
    wr(8'h01, 16'h0020);
    chk("R8 pulse high", {15'd0, clr_event_o}, 16'd1);
    rd(8'h01, v);
    chk("R8 bit5 reads 0", v, 16'h0000);
    @(negedge clk_i);
    chk("R8 pulse one cycle", {15'd0, clr_event_o}, 16'd0);
    intr_mode_i = 1'b0;
    wr(8'h01, 16'h0020);
    chk("R8 no pulse in comparator", {15'd0, clr_event_o}, 16'd0);
  endtask

  task automatic gate(input logic [7:0] a, output logic c, output logic w);
    @(negedge clk_i);
    addr_i = a; wdata_i = 16'h1234; we_i = 1'b1;
    #1 c = crit_we_o; w = win_we_o;
    @(posedge clk_i);
    #1 we_i = 1'b0;
  endtask

  task automatic t_locks();
    logic [15:0] v;
    logic c, w;
    do_reset();
    gate(8'h04, c, w); chk("R6 crit open", {14'd0, c, w}, 16'b10);
    gate(8'h02, c, w); chk("R7 upper open", {14'd0, c, w}, 16'b01);
    gate(8'h03, c, w); chk("R7 lower open", {14'd0, c, w}, 16'b01);
    wr(8'h01, 16'h0080);
    rd(8'h01, v); chk("R2 crit lock set", v, 16'h0080);
    gate(8'h04, c, w); chk("R6 crit blocked", {14'd0, c, w}, 16'b00);
    gate(8'h02, c, w); chk("R7 window still open", {14'd0, c, w}, 16'b01);
    wr(8'h01, 16'h0000);
    rd(8'h01, v); chk("R2 lock survives write 0", v, 16'h0080);
    wr(8'h01, 16'h0100);
    chk("R3 sd refused under lock", {15'd0, shutdown_o}, 16'd0);
    wr(8'h01, 16'h0040);
    rd(8'h01, v); chk("R2 both locks", v, 16'h00C0);
    gate(8'h03, c, w); chk("R7 lower blocked", {14'd0, c, w}, 16'b00);
    gate(8'h02, c, w); chk("R7 upper blocked", {14'd0, c, w}, 16'b00);
  endtask

  task automatic t_same_write();
    logic [15:0] v;
    do_reset();
    wr(8'h01, 16'h0180);
    rd(8'h01, v); chk("R5 lock+sd from clean", v, 16'h0180);
    wr(8'h01, 16'h0080);
    chk("R4 sd exit while locked", {15'd0, shutdown_o}, 16'd0);
    do_reset();
    wr(8'h01, 16'h0040);
    wr(8'h01, 16'h0140);
    rd(8'h01, v); chk("R5 sd refused, prior lock", v, 16'h0040);
  endtask

  task automatic t_other_addr();
    logic [15:0] v;
    do_reset();
    wr(8'h02, 16'h01C0);
    wr(8'h00, 16'h01C0);
    rd(8'h01, v); chk("R10 foreign write ignored", v, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_shutdown();
    t_status_rsvd();
    t_clear();
    t_locks();
    t_same_write();
    t_other_addr();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule